// File: doc/BRIEF.md
# Hardware Page Table Walker

This block resolves translation-buffer misses without software help. When the translation buffer reports a missing 20-bit virtual page number, the walker takes it, together with the current page table base address. It forms the address of the matching 32-bit page table entry and issues one read on a simple request/response memory port. It then waits, for as long as the memory needs, for the response.

The returned entry decides the outcome. If the entry's present bit is set, the walker hands the physical page number and the entry's attribute bits to the buffer's refill port, and the faulting access can be retried. If the present bit is clear, the page is not resident in main memory. In that case the walker raises a page fault that carries the virtual page number, and it writes nothing into the buffer.

The walker handles one miss at a time and holds further misses off until the current walk has finished. Only a single-level table is walked.

Top module: `ptw_walker`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `miss_ready` is 1 and `mem_req_valid`, `refill_valid` and `fault_valid` are 0.
- R2: A miss is taken on a clock edge where `miss_valid` and `miss_ready` are both 1. `miss_ready` is 0 from the next cycle until the walk ends. A `miss_valid` seen while `miss_ready` is 0 is ignored.
- R3: The cycle after a miss is taken, `mem_req_valid` is 1 for exactly one cycle. `mem_req_addr` equals the `ptbr` value sampled when the miss was taken plus 4 times the virtual page number, so later changes of `ptbr` do not affect the walk.
- R4: After the request, the walker waits any number of cycles for `mem_resp_valid`. A `mem_resp_valid` pulse that arrives while no request is outstanding (idle, or the request cycle itself) is ignored.
- R5: If bit 31 of the returned entry is 1, `refill_valid` is 1 for one cycle, in the cycle after the response. In that cycle `refill_ppn` is entry bits 17:0, `refill_attr` is entry bits 30:18, and `refill_vpn` is the missing page number.
- R6: If bit 31 of the returned entry is 0, `fault_valid` is 1 for one cycle, in the cycle after the response, with `fault_vpn` equal to the missing page number. No refill occurs for that walk.
- R7: `refill_valid` and `fault_valid` are never 1 together, and each walk ends in exactly one of them. `miss_ready` is 1 again in the cycle after either one.
- R8: The entry address is computed modulo 2^32, so a base near the top of the address space wraps around to low addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Translation-buffer miss pending |
| miss_vpn | input | 20 | Missing virtual page number |
| miss_ready | output | 1 | Walker idle and able to take a miss |
| ptbr | input | 32 | Page table base address |
| mem_req_valid | output | 1 | Page table entry read request |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_resp_valid | input | 1 | Read data valid |
| mem_resp_data | input | 32 | Returned page table entry |
| refill_valid | output | 1 | Write translation into the buffer |
| refill_vpn | output | 20 | Virtual page number being refilled |
| refill_ppn | output | 18 | Physical page number |
| refill_attr | output | 13 | Attribute bits copied from the entry (dirty, referenced, access) |
| fault_valid | output | 1 | Page fault for software |
| fault_vpn | output | 20 | Virtual page number that faulted |

## Verification
The hardest situations to reach from the ports are stray responses and competing misses that arrive while the walker is not waiting for them. Examples are a response pulse that carries a present bit during the request cycle, or a new miss held high throughout a walk. If the walker took either one, it would produce a wrong refill or start a second walk. To reach these cases, the stimulus injects such pulses at exact cycles chosen relative to the miss it just handed over. It also changes the base address right after acceptance, varies the response latency from zero to dozens of cycles, and uses a base that makes the entry address wrap.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VPN_W         = 20;
    localparam int PPN_W         = 18;
    localparam int ADDR_W        = 32;
    localparam int PTE_W         = 32;
    localparam int PTE_BYTES     = PTE_W / 8;
    localparam int ENTRY_SHIFT   = $clog2(PTE_BYTES);
    localparam int PRESENT_BIT   = PTE_W - 1;
    localparam int ATTR_LO       = PPN_W;
    localparam int ATTR_HI       = PTE_W - 2;
    localparam int ATTR_W        = ATTR_HI - ATTR_LO + 1;
    localparam int PAD_W         = ADDR_W - VPN_W - ENTRY_SHIFT;

    typedef enum logic [2:0] {
        WK_IDLE   = 3'd0,
        WK_REQ    = 3'd1,
        WK_WAIT   = 3'd2,
        WK_REFILL = 3'd3,
        WK_FAULT  = 3'd4
    } walk_state_e;

    typedef struct packed {
        logic              present;
        logic [ATTR_W-1:0] attr;
        logic [PPN_W-1:0]  ppn;
    } pte_view_t;

    function automatic pte_view_t pte_split(input logic [PTE_W-1:0] raw);
        pte_view_t v;
        v.present = raw[PRESENT_BIT];
        v.attr    = raw[ATTR_HI:ATTR_LO];
        v.ppn     = raw[PPN_W-1:0];
        return v;
    endfunction

    function automatic logic [ADDR_W-1:0] entry_addr(
        input logic [ADDR_W-1:0] base,
        input logic [VPN_W-1:0]  vpn
    );
        logic [ADDR_W-1:0] offs;
        offs = {{PAD_W{1'b0}}, vpn, {ENTRY_SHIFT{1'b0}}};
        return base + offs;
    endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic [ADDR_W-1:0] base,
    input  logic [VPN_W-1:0]  vpn,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        addr = entry_addr(base, vpn);
    end
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0] raw,
    output pte_view_t        view
);
    always_comb begin
        view = pte_split(raw);
    end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        miss_valid,
    input  logic        resp_valid,
    input  logic        present,
    output walk_state_e state,
    output logic        take_miss,
    output logic        take_resp
);
    walk_state_e state_d;

    always_comb begin
        take_miss = (state == WK_IDLE) && miss_valid;
        take_resp = (state == WK_WAIT) && resp_valid;
        state_d   = state;
        unique case (state)
            WK_IDLE:   if (miss_valid) state_d = WK_REQ;
            WK_REQ:    state_d = WK_WAIT;
            WK_WAIT:   if (resp_valid) state_d = present ? WK_REFILL : WK_FAULT;
            WK_REFILL: state_d = WK_IDLE;
            WK_FAULT:  state_d = WK_IDLE;
            default:   state_d = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= WK_IDLE;
        else     state <= state_d;
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    input  logic [VPN_W-1:0]  miss_vpn,
    output logic              miss_ready,
    input  logic [ADDR_W-1:0] ptbr,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_resp_valid,
    input  logic [PTE_W-1:0]  mem_resp_data,
    output logic              refill_valid,
    output logic [VPN_W-1:0]  refill_vpn,
    output logic [PPN_W-1:0]  refill_ppn,
    output logic [ATTR_W-1:0] refill_attr,
    output logic              fault_valid,
    output logic [VPN_W-1:0]  fault_vpn
);
    walk_state_e       state;
    logic              take_miss;
    logic              take_resp;
    logic [VPN_W-1:0]  vpn_q;
    logic [ADDR_W-1:0] base_q;
    logic [PTE_W-1:0]  pte_q;
    pte_view_t         resp_view;
    pte_view_t         held_view;

    ptw_pte_decode u_resp_dec (.raw(mem_resp_data), .view(resp_view));
    ptw_pte_decode u_held_dec (.raw(pte_q),         .view(held_view));

    ptw_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .miss_valid (miss_valid),
        .resp_valid (mem_resp_valid),
        .present    (resp_view.present),
        .state      (state),
        .take_miss  (take_miss),
        .take_resp  (take_resp)
    );

    ptw_addr_gen u_addr (.base(base_q), .vpn(vpn_q), .addr(mem_req_addr));

    always_ff @(posedge clk) begin
        if (rst) begin
            vpn_q  <= '0;
            base_q <= '0;
            pte_q  <= '0;
        end else begin
            if (take_miss) begin
                vpn_q  <= miss_vpn;
                base_q <= ptbr;
            end
            if (take_resp) pte_q <= mem_resp_data;
        end
    end

    always_comb begin
        miss_ready    = (state == WK_IDLE);
        mem_req_valid = (state == WK_REQ);
        refill_valid  = (state == WK_REFILL);
        fault_valid   = (state == WK_FAULT);
        refill_vpn    = vpn_q;
        fault_vpn     = vpn_q;
        refill_ppn    = held_view.ppn;
        refill_attr   = held_view.attr;
    end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
    import ptw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              miss_valid,
    input logic [VPN_W-1:0]  miss_vpn,
    input logic              miss_ready,
    input logic [ADDR_W-1:0] ptbr,
    input logic              mem_req_valid,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_resp_valid,
    input logic [PTE_W-1:0]  mem_resp_data,
    input logic              refill_valid,
    input logic [PPN_W-1:0]  refill_ppn,
    input logic              fault_valid
);
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !miss_ready); // R2
    AST_REQ_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && miss_ready) |=> mem_req_valid); // R3
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid); // R3
    AST_REQ_ADDR: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && miss_ready) |=>
            (mem_req_addr == $past(ptbr) + {{PAD_W{1'b0}}, $past(miss_vpn), {ENTRY_SHIFT{1'b0}}})); // R8
    AST_REFILL_SRC: assert property (@(posedge clk) disable iff (rst)
        refill_valid |-> ($past(mem_resp_valid) && $past(mem_resp_data[PRESENT_BIT])
                          && refill_ppn == $past(mem_resp_data[PPN_W-1:0]))); // R5
    AST_FAULT_SRC: assert property (@(posedge clk) disable iff (rst)
        fault_valid |-> ($past(mem_resp_valid) && !$past(mem_resp_data[PRESENT_BIT]))); // R6
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        !(refill_valid && fault_valid)); // R7
    AST_READY_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        (refill_valid || fault_valid) |=> miss_ready); // R7
endmodule

bind ptw_walker ptw_walker_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .miss_valid     (miss_valid),
    .miss_vpn       (miss_vpn),
    .miss_ready     (miss_ready),
    .ptbr           (ptbr),
    .mem_req_valid  (mem_req_valid),
    .mem_req_addr   (mem_req_addr),
    .mem_resp_valid (mem_resp_valid),
    .mem_resp_data  (mem_resp_data),
    .refill_valid   (refill_valid),
    .refill_ppn     (refill_ppn),
    .fault_valid    (fault_valid)
);

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
    logic        clk = 0;
    logic        rst = 1;
    logic        miss_valid = 0;
    logic [19:0] miss_vpn = 0;
    logic        miss_ready;
    logic [31:0] ptbr = 0;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_resp_valid = 0;
    logic [31:0] mem_resp_data = 0;
    logic        refill_valid;
    logic [19:0] refill_vpn;
    logic [17:0] refill_ppn;
    logic [12:0] refill_attr;
    logic        fault_valid;
    logic [19:0] fault_vpn;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ptw_walker u_dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // memory responder: variable latency, entry content derived from address
    int          lat = 0;
    bit          want_present = 1;
    bit          pend = 0;
    int          cnt = 0;
    logic [31:0] pdata = 0;

    function automatic logic [31:0] make_pte(input logic [31:0] a, input bit p);
        return {p, a[14:2], a[19:2] ^ 18'h2A5A5};
    endfunction

    always @(negedge clk) begin
        mem_resp_valid = 0;
        if (rst) pend = 0;
        else begin
            if (pend) begin
                if (cnt == 0) begin
                    mem_resp_valid = 1;
                    mem_resp_data  = pdata;
                    pend = 0;
                end else cnt--;
            end
            if (mem_req_valid) begin
                pend  = 1;
                cnt   = lat;
                pdata = make_pte(mem_req_addr, want_present);
            end
        end
    end

    // behavioural reference: phase 0 idle, 1 request, 2 waiting, 3 refill, 4 fault
    int          m_phase = 0;
    logic [19:0] m_vpn = 0;
    logic [31:0] m_base = 0;
    logic [31:0] m_pte = 0;
    int          exp_refills = 0, exp_faults = 0, got_refills = 0, got_faults = 0;

    always @(posedge clk) begin
        if (rst) m_phase = 0;
        else begin
            if (refill_valid) got_refills++;
            if (fault_valid)  got_faults++;
            case (m_phase)
                0: if (miss_valid) begin m_vpn = miss_vpn; m_base = ptbr; m_phase = 1; end
                1: m_phase = 2;
                2: if (mem_resp_valid) begin
                       m_pte = mem_resp_data;
                       if (mem_resp_data[31]) begin m_phase = 3; exp_refills++; end
                       else begin m_phase = 4; exp_faults++; end
                   end
                default: m_phase = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            logic [31:0] ea;
            ea = m_base + {10'b0, m_vpn, 2'b00};
            chk(miss_ready == (m_phase == 0), "R2 miss_ready", 32'(miss_ready), 32'(m_phase == 0));
            chk(mem_req_valid == (m_phase == 1), "R3 mem_req_valid", 32'(mem_req_valid), 32'(m_phase == 1));
            if (m_phase == 1) chk(mem_req_addr == ea, "R3/R8 mem_req_addr", mem_req_addr, ea);
            chk(refill_valid == (m_phase == 3), "R5 refill_valid", 32'(refill_valid), 32'(m_phase == 3));
            if (m_phase == 3) begin
                chk(refill_ppn == m_pte[17:0], "R5 refill_ppn", 32'(refill_ppn), 32'(m_pte[17:0]));
                chk(refill_attr == m_pte[30:18], "R5 refill_attr", 32'(refill_attr), 32'(m_pte[30:18]));
                chk(refill_vpn == m_vpn, "R5 refill_vpn", 32'(refill_vpn), 32'(m_vpn));
            end
            chk(fault_valid == (m_phase == 4), "R6 fault_valid", 32'(fault_valid), 32'(m_phase == 4));
            if (m_phase == 4) chk(fault_vpn == m_vpn, "R6 fault_vpn", 32'(fault_vpn), 32'(m_vpn));
            chk(!(refill_valid && fault_valid), "R7 exclusive", 32'({refill_valid, fault_valid}), 32'h0);
        end
    end

    task automatic walk(input logic [19:0] vpn, input logic [31:0] base, input bit p, input int l, input bit noisy);
        @(negedge clk);
        while (!miss_ready) @(negedge clk);
        #1;
        want_present = p; lat = l;
        miss_vpn = vpn; ptbr = base; miss_valid = 1;
        @(negedge clk); #1;
        ptbr = ~base;                 // R3: late base change must not matter
        miss_valid = noisy;           // R2: competing miss while busy
        miss_vpn = ~vpn;
        if (noisy) begin              // R4: stray response during request cycle
            mem_resp_valid = 1;
            mem_resp_data  = 32'h8000_0000 | {12'h0, ~vpn};
        end
        forever begin
            @(negedge clk);
            if (miss_ready) break;
        end
        #1 miss_valid = 0;
    endtask

    task automatic stray_idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            mem_resp_valid = 1;
            mem_resp_data  = 32'h8123_4567;
        end
        @(negedge clk);
        chk(!refill_valid && !fault_valid && miss_ready, "R4 stray response ignored",
            32'({refill_valid, fault_valid, miss_ready}), 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(miss_ready && !mem_req_valid && !refill_valid && !fault_valid, "R1 reset state",
            32'({miss_ready, mem_req_valid, refill_valid, fault_valid}), 32'h8);
        #1 rst = 0;
        @(negedge clk);
        chk(miss_ready && !mem_req_valid && !refill_valid && !fault_valid, "R1 after reset",
            32'({miss_ready, mem_req_valid, refill_valid, fault_valid}), 32'h8);

        walk(20'h00001, 32'h0010_0000, 1, 0, 0);   // R5 zero latency
        walk(20'hABCDE, 32'h0020_0000, 1, 3, 0);   // R5
        walk(20'h12345, 32'h0030_0000, 0, 1, 0);   // R6
        walk(20'hFFFFF, 32'h0040_0000, 1, 40, 1);  // R4 long wait, R2 noise
        walk(20'h00500, 32'hFFFF_F000, 1, 2, 0);   // R8 wrap
        walk(20'h3C3C3, 32'hFFFF_FFFC, 0, 7, 1);   // R8 wrap + R6 + noise
        stray_idle(3);                             // R4
        walk(20'h0F0F0, 32'h1234_5000, 1, 1, 1);   // R3 late base change
        walk(20'h00000, 32'h0000_0000, 0, 0, 1);   // R6
        for (int i = 0; i < 12; i++)
            walk(20'(i * 32'h1F3D7), 32'h0800_0000 + 32'(i << 12), i[0], i * 3, i[1]);

        repeat (4) @(negedge clk);
        chk(got_refills == exp_refills, "R5 refill count", 32'(got_refills), 32'(exp_refills));
        chk(got_faults == exp_faults, "R6 fault count", 32'(got_faults), 32'(exp_faults));
        chk(exp_refills + exp_faults == 20, "R7 one outcome per walk", 32'(exp_refills + exp_faults), 32'd20);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule